// File: doc/BRIEF.md
# Unipolar Threshold Switch with Hysteresis

This block turns a signed, sampled magnetic field value into the on/off decision of a unipolar field switch. A 6-bit trim code sets the operate point on a fixed grid of gauss steps. A 2-bit code picks one of four hysteresis widths, and the release point sits that width below the operate point. The output `sw_out_n` is active low. It goes low (on) when the field rises strictly above the operate point, and it goes high (off) when the field falls strictly below the release point. Inside the band the output keeps its state.

At start-up, and again every time `pwr_ok` drops, the output is forced on. A hold counter then counts timebase ticks while `pwr_ok` is high. When the hold interval ends, the switch state starts from off, whatever the field is. From the next clock on, it follows the thresholds. A field in the band therefore reads as off until a real crossing happens. The field uses one count per gauss, with south positive and north negative. The trim codes come from a separate configuration source.

Top module: `field_switch`

## Requirements
- R1: The operate point in gauss is `OP_BASE_G + OP_STEP_G * op_code`, which gives 10 G at code 0 and 325 G at code 63 with the default parameters.
- R2: `hys_code` 0, 1, 2 and 3 select hysteresis widths of 10, 15, 20 and 30 G by default. The release point equals the operate point minus the selected width.
- R3: Once the hold has ended, a field strictly greater than the operate point drives `sw_out_n` low at the next clock edge.
- R4: Once the hold has ended, a field strictly less than the release point drives `sw_out_n` high at the next clock edge.
- R5: A field equal to the operate point, equal to the release point, or between them leaves `sw_out_n` unchanged.
- R6: After reset, and after `pwr_ok` rises, `sw_out_n` is held low whatever the field until `HOLD_TICKS` tick pulses (default 25) have been sampled with `pwr_ok` high. Ticks sampled while `pwr_ok` is low are not counted.
- R7: If `pwr_ok` is low at a clock edge, `sw_out_n` is low after that edge and the hold count restarts from zero.
- R8: For the first cycle after the hold ends, `sw_out_n` is high (off) whatever the field. Threshold evaluation starts at the following edge.
- R9: The field and the thresholds are compared as signed values. A release point below zero (north) takes effect, so a small north field does not release the switch, but a field below a negative release point does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply-valid flag; low restarts the hold |
| tick | input | 1 | Timebase pulse, one cycle wide, for the hold count |
| field | input | FIELD_W (16) | Signed field sample, one count per gauss, south positive |
| op_code | input | TRIM_W (6) | Operate-point trim code |
| hys_code | input | 2 | Hysteresis width select |
| sw_out_n | output | 1 | Switch output, low = on |

## Verification
On every cycle, the assertions check the threshold state transitions: a set above the operate point, a clear below the release point, and no change in the band or at equality. They also check that the release point stays below the operate point, that the hold ends only on a tick, that the output is low after any edge with `pwr_ok` low, and that the output is off on the first cycle after the hold. Only the directed scenarios can show the exact length of the hold in ticks, the restart of the count after a supply drop, the operate and release points in gauss for each trim and hysteresis code, and the handling of a negative release point.

// File: rtl/field_switch_pkg.sv
package field_switch_pkg;

  // Operate point in gauss for a trim code.
  function automatic int op_gauss(input int base_g, input int step_g, input int code);
    return base_g + step_g * code;
  endfunction

  // Hysteresis width in gauss for a 2-bit select.
  function automatic int hys_gauss(input logic [1:0] sel, input int h0, input int h1,
                                   input int h2, input int h3);
    case (sel)
      2'd0:    return h0;
      2'd1:    return h1;
      2'd2:    return h2;
      default: return h3;
    endcase
  endfunction

endpackage

// File: rtl/fs_thresholds.sv
module fs_thresholds
  import field_switch_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int TRIM_W    = 6,
  parameter int OP_BASE_G = 10,
  parameter int OP_STEP_G = 5,
  parameter int HYS_G0    = 10,
  parameter int HYS_G1    = 15,
  parameter int HYS_G2    = 20,
  parameter int HYS_G3    = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TRIM_W-1:0]          op_code,
  input  logic [1:0]                 hys_code,
  output logic signed [FIELD_W-1:0]  op_thr,
  output logic signed [FIELD_W-1:0]  rel_thr
);

  int op_i;
  int rel_i;

  always_comb begin
    op_i  = op_gauss(OP_BASE_G, OP_STEP_G, int'(op_code));
    rel_i = op_i - hys_gauss(hys_code, HYS_G0, HYS_G1, HYS_G2, HYS_G3);
  end

  assign op_thr  = FIELD_W'(op_i);
  assign rel_thr = FIELD_W'(rel_i);

  AST_REL_BELOW_OP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_thr < op_thr); // R2

endmodule

// File: rtl/fs_por_hold.sv
module fs_por_hold #(
  parameter int HOLD_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic tick,
  output logic ready,
  output logic hold_end
);

  localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  assign hold_end = pwr_ok && tick && !ready && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!pwr_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (hold_end) begin
      ready <= 1'b1;
    end else if (tick && !ready) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_HOLD_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick) && $past(pwr_ok)); // R6

  AST_PWR_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !ready); // R7

endmodule

// File: rtl/fs_hyst_state.sv
module fs_hyst_state #(
  parameter int FIELD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ready,
  input  logic signed [FIELD_W-1:0] field,
  input  logic signed [FIELD_W-1:0] op_thr,
  input  logic signed [FIELD_W-1:0] rel_thr,
  output logic                      sw_on
);

  logic above_op;
  logic below_rel;

  assign above_op  = field > op_thr;
  assign below_rel = field < rel_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sw_on <= 1'b0;
    else if (!ready)    sw_on <= 1'b0;
    else if (above_op)  sw_on <= 1'b1;
    else if (below_rel) sw_on <= 1'b0;
  end

  AST_SET_ABOVE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    ready && above_op |=> sw_on); // R3

  AST_CLEAR_BELOW_REL: assert property (@(posedge clk) disable iff (!rst_n)
    ready && below_rel |=> !sw_on); // R4

  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && (field <= op_thr) && (field >= rel_thr) |=> $stable(sw_on)); // R5

endmodule

// File: rtl/field_switch.sv
module field_switch #(
  parameter int FIELD_W    = 16,
  parameter int TRIM_W     = 6,
  parameter int OP_BASE_G  = 10,
  parameter int OP_STEP_G  = 5,
  parameter int HYS_G0     = 10,
  parameter int HYS_G1     = 15,
  parameter int HYS_G2     = 20,
  parameter int HYS_G3     = 30,
  parameter int HOLD_TICKS = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwr_ok,
  input  logic                      tick,
  input  logic signed [FIELD_W-1:0] field,
  input  logic [TRIM_W-1:0]         op_code,
  input  logic [1:0]                hys_code,
  output logic                      sw_out_n
);

  logic signed [FIELD_W-1:0] op_thr;
  logic signed [FIELD_W-1:0] rel_thr;
  logic                      ready;
  logic                      hold_end;
  logic                      sw_on;

  fs_thresholds #(
    .FIELD_W(FIELD_W), .TRIM_W(TRIM_W), .OP_BASE_G(OP_BASE_G), .OP_STEP_G(OP_STEP_G),
    .HYS_G0(HYS_G0), .HYS_G1(HYS_G1), .HYS_G2(HYS_G2), .HYS_G3(HYS_G3)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .hys_code(hys_code),
    .op_thr(op_thr), .rel_thr(rel_thr)
  );

  fs_por_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tick(tick),
    .ready(ready), .hold_end(hold_end)
  );

  fs_hyst_state #(.FIELD_W(FIELD_W)) u_state (
    .clk(clk), .rst_n(rst_n), .ready(ready), .field(field),
    .op_thr(op_thr), .rel_thr(rel_thr), .sw_on(sw_on)
  );

  assign sw_out_n = ready ? ~sw_on : 1'b0;

  AST_PWR_LOW_FORCES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !sw_out_n); // R7

  AST_HOLD_EXIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> sw_out_n); // R8

  AST_HOLD_END_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |=> ready); // R6

endmodule

// File: tb/field_switch_tb.sv
module field_switch_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pwr_ok = 1'b0;
  logic               tick = 1'b0;
  logic signed [15:0] field = '0;
  logic [5:0]         op_code = '0;
  logic [1:0]         hys_code = '0;
  logic               sw_out_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  field_switch u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tick(tick), .field(field),
    .op_code(op_code), .hys_code(hys_code), .sw_out_n(sw_out_n)
  );

  function automatic int exp_op(input int code);
    return 10 + code * 5;
  endfunction

  function automatic int exp_rel(input int code, input int hc);
    int w;
    w = (hc == 0) ? 10 : (hc == 1) ? 15 : (hc == 2) ? 20 : 30;
    return exp_op(code) - w;
  endfunction

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (sw_out_n !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_out_n actual=%b expected=%b", tag, sw_out_n, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step();
      tick = 1'b0; step();
    end
  endtask

  // R6 R8 R3: hold from reset, with a strong field present
  task automatic t_hold_from_reset();
    check(1'b0, "R6 in reset");
    field = 16'sd1000;
    step(); rst_n = 1'b1; pwr_ok = 1'b1;
    step();
    ticks(HOLD - 1);
    check(1'b0, "R6 hold before last tick");
    tick = 1'b1; step(); tick = 1'b0;
    check(1'b1, "R8 first cycle after hold");
    step();
    check(1'b0, "R3 strong field after hold");
  endtask

  // R1 R2 R3 R4 R5 for one code pair
  task automatic t_thresh(input int code, input int hc);
    int op;
    int rel;
    op = exp_op(code); rel = exp_rel(code, hc);
    op_code = 6'(code); hys_code = 2'(hc);
    field = 16'(rel - 1); step();
    check(1'b1, "R4 below release");
    field = 16'(op); step();
    check(1'b1, "R5 equal operate point");
    field = 16'(op + 1); step();
    check(1'b0, "R1 R3 just above operate point");
    field = 16'(rel); step();
    check(1'b0, "R2 R5 equal release point");
    field = 16'((op + rel) / 2); step();
    check(1'b0, "R5 inside band");
    field = 16'(rel - 1); step();
    check(1'b1, "R2 R4 just below release point");
  endtask

  // R9: negative release point
  task automatic t_north();
    op_code = 6'd0; hys_code = 2'd3;
    field = 16'sd11; step();
    check(1'b0, "R9 set at code 0");
    field = -16'sd5; step();
    check(1'b0, "R9 small north field holds");
    field = -16'sd20; step();
    check(1'b0, "R9 equal negative release");
    field = -16'sd21; step();
    check(1'b1, "R9 below negative release");
  endtask

  // R7 R6: supply drop restarts the hold, ticks ignored while low
  task automatic t_power();
    field = 16'sd0; step();
    check(1'b1, "R8 off in band before drop");
    pwr_ok = 1'b0; step();
    check(1'b0, "R7 supply low forces on");
    ticks(30);
    check(1'b0, "R7 ticks while low");
    pwr_ok = 1'b1; step();
    ticks(10);
    check(1'b0, "R6 partial hold");
    pwr_ok = 1'b0; step();
    pwr_ok = 1'b1; step();
    ticks(HOLD - 1);
    check(1'b0, "R6 R7 count restarted");
    tick = 1'b1; step(); tick = 1'b0;
    check(1'b1, "R8 band reads off after hold");
    step(); step();
    check(1'b1, "R5 band stays off");
  endtask

  localparam int HOLD = 25;

  initial begin
    step(); step();
    t_hold_from_reset();
    t_thresh(0, 0);
    t_thresh(63, 3);
    t_thresh(20, 1);
    t_thresh(7, 2);
    t_north();
    t_power();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule